// File: doc/BRIEF.md
# Fractional-N Bit-Clock Generator

This block derives a serial line clock from a fast reference clock. Every reference cycle is one bit-time of the output. The output is a square-ish waveform whose level inverts at every state boundary. A repeat of the pattern has two parts. First comes a run of short states, each `A` reference cycles wide. Then comes a run of long states, each `A+1` reference cycles wide. The average output frequency therefore lies between the two integer divisions of half the reference rate: `(ref/2)/(A + (B+1)/(C+1))`.

The three parameters arrive packed in one 32-bit configuration word with a load strobe. A loaded word is held pending and becomes active only when the current repeat ends, so no partial pattern is ever produced. The sequencer is a two-state machine:

- `ST_SHORT` emits the short run.
- `ST_LONG` emits the long run.

Its transitions are as follows:

- **short-to-long**: taken when the last cycle of the last short state ends.
- **long-to-short**: taken at the end of a repeat when the configuration for the next repeat has a non-empty short run.
- **long-to-long**: taken at the end of a repeat when the next short run is empty. It also covers staying in `ST_LONG` while states remain.
- **short-to-short**: staying in `ST_SHORT` while short states remain.

Top module: `fnclk_gen`

## Requirements
- R1: The configuration word carries A in bits [31:22], B in bits [21:12] and C in bits [11:0], all unsigned.
- R2: While reset is asserted and in the first cycle after it, the output is high. The first state after reset is the first short state, or the first long state if the reset configuration has no short run.
- R3: The output holds its level for the whole of a state and inverts at every state boundary, including the boundaries between runs and between repeats.
- R4: Each repeat emits (C − B) short states of A cycles each, followed by (B + 1) long states of A + 1 cycles each.
- R5: A repeat lasts (C − B)·A + (B + 1)·(A + 1) cycles, and the next repeat follows with no gap.
- R6: When C ≤ B, the short run is omitted and the repeat consists only of the B + 1 long states.
- R7: When A = 0, the short run is omitted and the long states are one cycle wide.
- R8: With the minimal setting A=0, B=1, C=1, the output inverts on every reference cycle.
- R9: A word loaded by the strobe becomes active at the first repeat end at or after the load cycle. When several words are loaded before that end, the last one wins. The repeat in progress is never altered.
- R10: With A=2, B=2, C=7, the repeat is the 19-bit sequence 1100110011 000111000, assuming it starts at the high level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; one cycle is one output bit-time |
| rst | input | 1 | Synchronous reset, active high |
| cfg_word | input | 32 | Packed configuration word (A, B, C) |
| cfg_load | input | 1 | Strobe that captures `cfg_word` as the pending configuration |
| clk_out | output | 1 | Generated clock level |

## Verification
A wrong cycle counter or a miscounted run shows at the output as one state that is too short or too long. Every inversion after that point is then shifted, so a cycle-exact comparison of the output fails within one state width of the fault. A configuration taken at the wrong moment corrupts the repeat in progress. The bench sees this within the same repeat, because its model only changes parameters at the end of a repeat. A state machine that enters the short run when the run is empty would produce zero-width or A-wide states where A+1-wide states are expected. That shows up at the first boundary after the end of the repeat.

// File: rtl/fnclk_pkg.sv
`timescale 1ns/1ps
package fnclk_pkg;

    localparam int A_W   = 10;
    localparam int B_W   = 10;
    localparam int C_W   = 12;
    localparam int CFG_W = A_W + B_W + C_W;
    localparam int BIT_W = A_W + 1;
    localparam int CNT_W = (C_W > B_W + 1) ? C_W : B_W + 1;

    // Field order in the packed struct is the word layout (R1)
    typedef struct packed {
        logic [A_W-1:0] a;
        logic [B_W-1:0] b;
        logic [C_W-1:0] c;
    } cfg_t;

    typedef enum logic {
        ST_SHORT = 1'b0,
        ST_LONG  = 1'b1
    } run_e;

    // Number of short states in one repeat; zero when C <= B or A == 0
    function automatic logic [CNT_W-1:0] short_states(input cfg_t k);
        logic [C_W-1:0] b_ext;
        b_ext = C_W'(k.b);
        if ((k.a != '0) && (k.c > b_ext))
            return CNT_W'(k.c - b_ext);
        else
            return '0;
    endfunction

    // Number of long states in one repeat
    function automatic logic [CNT_W-1:0] long_states(input cfg_t k);
        return CNT_W'(k.b) + CNT_W'(1);
    endfunction

endpackage

// File: rtl/fnclk_cnt.sv
`timescale 1ns/1ps
module fnclk_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst || clr)
            q <= '0;
        else if (inc)
            q <= q + W'(1);
    end

endmodule

// File: rtl/fnclk_cfg_reg.sv
`timescale 1ns/1ps
module fnclk_cfg_reg
    import fnclk_pkg::*;
#(
    parameter logic [CFG_W-1:0] RESET_CFG = CFG_W'(32'h0000_1001)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CFG_W-1:0] word_i,
    input  logic             load_i,
    input  logic             take_i,
    output cfg_t             active_o,
    output cfg_t             upcoming_o
);

    cfg_t pend_q;

    // Configuration the next repeat will use if it started now
    assign upcoming_o = load_i ? cfg_t'(word_i) : pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_o <= cfg_t'(RESET_CFG);
            pend_q   <= cfg_t'(RESET_CFG);
        end else begin
            if (load_i)
                pend_q <= cfg_t'(word_i);
            if (take_i)
                active_o <= upcoming_o;
        end
    end

endmodule

// File: rtl/fnclk_gen.sv
`timescale 1ns/1ps
module fnclk_gen
    import fnclk_pkg::*;
#(
    parameter logic [31:0] RESET_CFG = 32'h0000_1001
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] cfg_word,
    input  logic        cfg_load,
    output logic        clk_out
);

    localparam cfg_t RST_K     = cfg_t'(RESET_CFG[CFG_W-1:0]);
    localparam run_e RST_STATE = (short_states(RST_K) != '0) ? ST_SHORT : ST_LONG;

    cfg_t             act;
    cfg_t             upc;
    run_e             state_q;
    run_e             state_d;
    logic [BIT_W-1:0] bit_q;
    logic [CNT_W-1:0] st_q;
    logic [BIT_W-1:0] width_cur;
    logic [CNT_W-1:0] count_cur;
    logic             bit_last;
    logic             run_end;
    logic             rep_end;

    // Active and pending configuration
    fnclk_cfg_reg #(
        .RESET_CFG (RESET_CFG[CFG_W-1:0])
    ) cfg_i (
        .clk        (clk),
        .rst        (rst),
        .word_i     (cfg_word[CFG_W-1:0]),
        .load_i     (cfg_load),
        .take_i     (rep_end),
        .active_o   (act),
        .upcoming_o (upc)
    );

    // Cycle position inside the current state
    fnclk_cnt #(
        .W (BIT_W)
    ) bitcnt_i (
        .clk (clk),
        .rst (rst),
        .clr (bit_last),
        .inc (1'b1),
        .q   (bit_q)
    );

    // State position inside the current run
    fnclk_cnt #(
        .W (CNT_W)
    ) stcnt_i (
        .clk (clk),
        .rst (rst),
        .clr (run_end),
        .inc (bit_last),
        .q   (st_q)
    );

    // Width and length of what is being emitted
    always_comb begin
        unique case (state_q)
            ST_SHORT: begin
                width_cur = BIT_W'(act.a);
                count_cur = short_states(act);
            end
            ST_LONG: begin
                width_cur = BIT_W'(act.a) + BIT_W'(1);
                count_cur = long_states(act);
            end
            default: begin
                width_cur = BIT_W'(1);
                count_cur = CNT_W'(1);
            end
        endcase
    end

    assign bit_last = (bit_q == width_cur - BIT_W'(1));
    assign run_end  = bit_last && (st_q == count_cur - CNT_W'(1));
    assign rep_end  = run_end && (state_q == ST_LONG);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SHORT: begin
                if (run_end)
                    state_d = ST_LONG;
            end
            ST_LONG: begin
                if (run_end)
                    state_d = (short_states(upc) != '0) ? ST_SHORT : ST_LONG;
            end
            default: state_d = ST_LONG;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst)
            state_q <= RST_STATE;
        else
            state_q <= state_d;
    end

    // Output level: inverts at every state boundary
    always_ff @(posedge clk) begin
        if (rst)
            clk_out <= 1'b1;
        else if (bit_last)
            clk_out <= ~clk_out;
    end

endmodule

// File: rtl/fnclk_gen_chk.sv
`timescale 1ns/1ps
module fnclk_gen_chk
    import fnclk_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 clk_out,
    input run_e                 state_q,
    input logic [BIT_W-1:0]     bit_q,
    input cfg_t                 act,
    input logic                 run_end,
    input logic                 rep_end
);

    AST_RESET_HIGH: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> clk_out);  // R2

    AST_HOLD_IN_STATE: assert property (@(posedge clk) disable iff (rst)
        (bit_q != '0) |-> $stable(clk_out));  // R3

    AST_FLIP_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        ((bit_q == '0) && !$past(rst)) |-> (clk_out != $past(clk_out)));  // R3

    AST_SHORT_THEN_LONG: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_SHORT) && run_end) |=> (state_q == ST_LONG));  // R4

    AST_SHORT_NEEDS_SPAN: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SHORT) |-> (act.c > C_W'(act.b)));  // R6

    AST_SHORT_NEEDS_WIDTH: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SHORT) |-> (act.a != '0));  // R7

    AST_CFG_ONLY_AT_END: assert property (@(posedge clk) disable iff (rst)
        !rep_end |=> $stable(act));  // R9

endmodule

bind fnclk_gen fnclk_gen_chk chk_i (
    .clk     (clk),
    .rst     (rst),
    .clk_out (clk_out),
    .state_q (state_q),
    .bit_q   (bit_q),
    .act     (act),
    .run_end (run_end),
    .rep_end (rep_end)
);

// File: tb/fnclk_gen_tb_top.sv
`timescale 1ns/1ps
module fnclk_gen_tb_top;

    localparam logic [31:0] RST_WORD = 32'h0000_1001;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_load = 1'b0;
    logic [31:0] cfg_word = '0;
    logic        clk_out;

    always #2.5 clk = ~clk;

    fnclk_gen #(.RESET_CFG(RST_WORD)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .cfg_word (cfg_word),
        .cfg_load (cfg_load),
        .clk_out  (clk_out)
    );

    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;
    bit          exp_q[$];
    bit          m_lvl;
    logic [31:0] m_pend;
    logic        cap [0:20];
    int          cap_n = 100;

    function automatic logic [31:0] mk(input int a, input int b, input int c);
        logic [31:0] w;
        w = {a[9:0], b[9:0], c[11:0]};  // R1 field layout
        return w;
    endfunction

    task automatic check(input string tag, input logic act_v, input logic exp_v);
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act_v, exp_v);
        end
    endtask

    // Append one full repeat of the expected waveform
    function automatic void refill(input logic [31:0] w);
        int a, b, c, ns;
        a  = int'(w[31:22]);
        b  = int'(w[21:12]);
        c  = int'(w[11:0]);
        ns = (a != 0 && c > b) ? c - b : 0;
        for (int i = 0; i < ns; i++) begin
            for (int j = 0; j < a; j++) exp_q.push_back(m_lvl);
            m_lvl = ~m_lvl;
        end
        for (int i = 0; i < b + 1; i++) begin
            for (int j = 0; j < a + 1; j++) exp_q.push_back(m_lvl);
            m_lvl = ~m_lvl;
        end
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        cfg_load = 1'b0;
        repeat (3) @(negedge clk);
        check("R2 level under reset", clk_out, 1'b1);
        exp_q.delete();
        m_lvl  = 1'b1;
        m_pend = RST_WORD;
        refill(m_pend);
        rst = 1'b0;
    endtask

    task automatic step(input bit ld, input logic [31:0] w, input string tag);
        bit e;
        e = exp_q.pop_front();
        check(tag, clk_out, e);
        if (cap_n < 21) begin
            cap[cap_n] = clk_out;
            cap_n++;
        end
        cfg_load = ld;
        if (ld) begin
            cfg_word = w;
            m_pend   = w;
        end
        if (exp_q.size() == 0) refill(m_pend);
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, '0, tag);
    endtask

    function automatic logic [31:0] rnd_word();
        int r;
        r = int'($urandom % 50);
        if (r == 0)      return mk(1023, 0, 1);
        else if (r == 1) return mk(1, 1000, 4095);
        else if (r < 6)  return mk(0, 1, 1);
        else             return mk(int'($urandom % 4), int'($urandom % 6), int'($urandom % 10));
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [18:0] pat;
        void'($urandom(32'd4242));
        pat = 19'b1100110011000111000;

        do_reset();
        cap_n = 0;
        // R2: first bit is high; R10 example loaded in the first cycle
        step(1'b1, mk(2, 2, 7), "R2 R10 first bit");
        idle(40, "R10 R3 example stream");
        for (int i = 0; i < 19; i++) begin
            checks++;
            if (cap[2 + i] !== pat[18 - i]) begin
                errors++;
                $display("FAIL R10 bit %0d: actual=%0b expected=%0b", i, cap[2 + i], pat[18 - i]);
            end
        end
        cap_n = 100;

        step(1'b1, mk(0, 1, 5), "R7 load");
        idle(40, "R7 zero short width");
        step(1'b1, mk(3, 5, 2), "R6 load");
        idle(60, "R6 C below B");
        step(1'b1, mk(2, 4, 4), "R6 load equal");
        idle(60, "R6 C equal B");
        step(1'b1, mk(0, 1, 1), "R8 load");
        idle(30, "R8 minimal setting");

        // R9: mid-repeat loads, last one wins
        step(1'b1, mk(5, 0, 3), "R9 load base");
        idle(30, "R9 base");
        step(1'b1, mk(1, 3, 6), "R9 load first");
        step(1'b1, mk(3, 1, 4), "R9 load second");
        idle(80, "R9 last wins");

        // Reset in the middle of a run restores defaults
        do_reset();
        idle(10, "R2 after second reset");

        for (int i = 0; i < 60000; i++)
            step(($urandom % 25) == 0, rnd_word(), "R1 R4 R5 R9 random");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule